// File: doc/BRIEF.md
# Dual Bus Memory Data Aligner

This block sits between two memory data buses and the register file. One bus carries 16-bit data words and the other carries 24-bit words. Every access carries three flags: which bus the instruction references, whether the addressed bank is 16 or 24 bits wide (decoded from the address elsewhere), and whether the instruction is a single-move form. The block uses these flags to justify the memory word into a 16-bit register value. It also steers the spare low byte of a wide word into an 8-bit extension register. For stores, it builds the memory write word together with per-byte lane enables.

The width of the addressed bank decides the alignment, whatever the bus reference says. A wide bank always delivers its upper 16 bits to the register. The extension register is loaded only by a dual-read form. It captures the low byte on a wide program-bus read. It is cleared when that read instead makes a 16-bit access, which is a program-bus read of a narrow bank or a data-bus read of a wide bank. Single-move forms always travel on the 16-bit data bus, so they never touch the extension register.

Top module: `mem_lane_aligner`

## Requirements
- R1: A read of a wide bank (`bank_wide`=1) gives `reg_wr_val` = `rd_data[23:8]`, for either bus reference and either form.
- R2: A read of a narrow bank (`bank_wide`=0) gives `reg_wr_val` = `rd_data[15:0]`, right-justified. `rd_data[23:16]` is ignored.
- R3: A dual-form (`single_form`=0) program-bus read (`ref_pm`=1) of a wide bank loads `ext_q` with `rd_data[7:0]` at the next clock edge.
- R4: A dual-form read that is a 16-bit access clears `ext_q` to zero at the next clock edge. This covers a program-bus read of a narrow bank and a data-bus read of a wide bank.
- R5: `ext_q` holds its value in three cases: no read, a single-form read (`ref_pm` is then ignored), and a dual-form data-bus read of a narrow bank.
- R6: A store to a wide bank drives `mem_wr_data` = {`st_data`, 8'h00} and `mem_wr_lanes` = 3'b111. Lane bit k enables memory bits 8k+7:8k.
- R7: A store to a narrow bank drives `mem_wr_data` = {8'h00, `st_data`} and `mem_wr_lanes` = 3'b011.
- R8: `reg_wr_en` follows `rd_en`. With no read, `reg_wr_val` is zero. With no store, `mem_wr_data` and `mem_wr_lanes` are zero.
- R9: Reset clears `ext_q` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | A memory read completes this cycle |
| wr_en | input | 1 | A memory store is issued this cycle |
| ref_pm | input | 1 | Instruction references the program-memory bus |
| bank_wide | input | 1 | Addressed bank is 24 bits wide |
| single_form | input | 1 | Single-move form, forced onto the data bus |
| rd_data | input | 24 | Memory read word, narrow-bank data in bits 15:0 |
| st_data | input | 16 | Register value to store |
| reg_wr_en | output | 1 | Register file write strobe |
| reg_wr_val | output | 16 | Justified register write value |
| ext_q | output | 8 | Extension register |
| mem_wr_data | output | 24 | Aligned store word |
| mem_wr_lanes | output | 3 | Byte lane enables for the store |

## Verification
The bench sweeps every combination of the five access flags against six data patterns. Each pattern has distinct upper, middle and low bytes, so a wrong byte slice shows up at once. Narrow-bank patterns put non-zero bits in 23:16, which exposes any leak of those bits into the register. Before each capture, the bench loads `ext_q` with a value that differs from the new low byte, so hold, clear and capture give three different results. A reset in the middle of the run, taken after the register has been loaded, confirms the clear.

// File: rtl/mem_lane_aligner.sv
module mem_lane_aligner #(
  parameter int RW = 16,
  parameter int XW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic            ref_pm,
  input  logic            bank_wide,
  input  logic            single_form,
  input  logic [RW+XW-1:0] rd_data,
  input  logic [RW-1:0]   st_data,
  output logic            reg_wr_en,
  output logic [RW-1:0]   reg_wr_val,
  output logic [XW-1:0]   ext_q,
  output logic [RW+XW-1:0] mem_wr_data,
  output logic [(RW+XW)/8-1:0] mem_wr_lanes
);
  localparam int MW = RW + XW;
  localparam int NL = MW / 8;
  localparam int NARROW_LANES = RW / 8;

  logic on_pm_bus, dual_rd, ext_cap, ext_clr;

  assign on_pm_bus = ref_pm & ~single_form;
  assign dual_rd   = rd_en & ~single_form;
  assign ext_cap   = dual_rd & on_pm_bus & bank_wide;
  assign ext_clr   = dual_rd & (on_pm_bus ^ bank_wide);

  assign reg_wr_en  = rd_en;
  assign reg_wr_val = !rd_en ? '0 :
                      bank_wide ? rd_data[MW-1:XW] : rd_data[RW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ext_q <= '0;
    else if (ext_cap) ext_q <= rd_data[XW-1:0];
    else if (ext_clr) ext_q <= '0;
  end

  assign mem_wr_data = !wr_en ? '0 :
                       bank_wide ? {st_data, {XW{1'b0}}} : {{XW{1'b0}}, st_data};

  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign mem_wr_lanes[k] = wr_en & (bank_wide | (k < NARROW_LANES));
  end
endmodule

module mem_lane_aligner_chk #(
  parameter int RW = 16,
  parameter int XW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_en,
  input logic            wr_en,
  input logic            ref_pm,
  input logic            bank_wide,
  input logic            single_form,
  input logic [RW+XW-1:0] rd_data,
  input logic [RW+XW-1:0] mem_wr_data,
  input logic [(RW+XW)/8-1:0] mem_wr_lanes,
  input logic [XW-1:0]   ext_q
);
  a_r3_ext_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !single_form && ref_pm && bank_wide) |=> ext_q == $past(rd_data[XW-1:0]));

  a_r4_ext_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !single_form && (ref_pm != bank_wide)) |=> ext_q == '0);

  a_r5_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || single_form || (!ref_pm && !bank_wide)) |=> $stable(ext_q));

  a_r6_wide_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bank_wide) |-> ($countones(mem_wr_lanes) == (RW+XW)/8 && mem_wr_data[XW-1:0] == '0));

  a_r7_narrow_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bank_wide) |-> (!mem_wr_lanes[(RW+XW)/8-1] && mem_wr_data[RW+XW-1:RW] == '0));

  a_r8_idle_store: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> mem_wr_lanes == '0);
endmodule

bind mem_lane_aligner mem_lane_aligner_chk #(.RW(RW), .XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .ref_pm(ref_pm),
  .bank_wide(bank_wide), .single_form(single_form), .rd_data(rd_data),
  .mem_wr_data(mem_wr_data), .mem_wr_lanes(mem_wr_lanes), .ext_q(ext_q)
);

// File: tb/mem_lane_aligner_bench.sv
`timescale 1ns/100ps
module mem_lane_aligner_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_en = 0, wr_en = 0, ref_pm = 0, bank_wide = 0, single_form = 0;
  logic [23:0] rd_data = '0;
  logic [15:0] st_data = '0;
  logic        reg_wr_en;
  logic [15:0] reg_wr_val;
  logic [7:0]  ext_q;
  logic [23:0] mem_wr_data;
  logic [2:0]  mem_wr_lanes;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] ext_m;

  always #2.5 clk = ~clk;

  mem_lane_aligner u_mem_lane_aligner (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .ref_pm(ref_pm),
    .bank_wide(bank_wide), .single_form(single_form), .rd_data(rd_data),
    .st_data(st_data), .reg_wr_en(reg_wr_en), .reg_wr_val(reg_wr_val),
    .ext_q(ext_q), .mem_wr_data(mem_wr_data), .mem_wr_lanes(mem_wr_lanes)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk(ext_q == 8'h00, "R9 reset", {24'd0, ext_q}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    ext_m = 8'h00;
    for (int p = 0; p < 6; p++) begin
      for (int f = 0; f < 32; f++) begin
        logic [23:0] d;
        logic [15:0] s;
        logic [15:0] er;
        logic [23:0] ew;
        logic [2:0]  el;
        logic [7:0]  en;
        d = 24'hC35A96 ^ (24'h1B2D4F * (p + 1)) ^ {8'(f), 8'(~f), 8'(f * 7)};
        if (d[7:0] == ext_m) d[7:0] = ~ext_m;
        s = 16'hA5F0 ^ 16'(p * 16'h1357) ^ 16'(f * 16'h0911);
        @(negedge clk);
        rd_en = f[0]; ref_pm = f[1]; bank_wide = f[2]; single_form = f[3]; wr_en = f[4];
        rd_data = d; st_data = s;
        #1;
        er = !f[0] ? 16'h0 : (f[2] ? d[23:8] : d[15:0]);
        ew = !f[4] ? 24'h0 : (f[2] ? {s, 8'h00} : {8'h00, s});
        el = !f[4] ? 3'b000 : (f[2] ? 3'b111 : 3'b011);
        chk(reg_wr_en == f[0], "R8 strobe", {31'd0, reg_wr_en}, {31'd0, f[0]});
        if (!f[0]) chk(reg_wr_val == er, "R8 idle read", {16'd0, reg_wr_val}, {16'd0, er});
        else if (f[2]) chk(reg_wr_val == er, "R1 wide read", {16'd0, reg_wr_val}, {16'd0, er});
        else chk(reg_wr_val == er, "R2 narrow read", {16'd0, reg_wr_val}, {16'd0, er});
        if (!f[4]) chk(mem_wr_data == ew && mem_wr_lanes == el, "R8 idle store",
                       {5'd0, mem_wr_lanes, mem_wr_data}, {5'd0, el, ew});
        else if (f[2]) chk(mem_wr_data == ew && mem_wr_lanes == el, "R6 wide store",
                       {5'd0, mem_wr_lanes, mem_wr_data}, {5'd0, el, ew});
        else chk(mem_wr_data == ew && mem_wr_lanes == el, "R7 narrow store",
                 {5'd0, mem_wr_lanes, mem_wr_data}, {5'd0, el, ew});
        en = ext_m;
        if (f[0] && !f[3]) begin
          if (f[1] && f[2]) en = d[7:0];
          else if (f[1] != f[2]) en = 8'h00;
        end
        @(posedge clk); #1;
        if (en != ext_m && en != 8'h00)
          chk(ext_q == en, "R3 capture", {24'd0, ext_q}, {24'd0, en});
        else if (f[0] && !f[3] && (f[1] != f[2]))
          chk(ext_q == en, "R4 clear", {24'd0, ext_q}, {24'd0, en});
        else
          chk(ext_q == en, "R5 hold", {24'd0, ext_q}, {24'd0, en});
        ext_m = en;
        if (ext_m == 8'h00) begin
          @(negedge clk);
          rd_en = 1; ref_pm = 1; bank_wide = 1; single_form = 0; wr_en = 0;
          rd_data = {16'h0, 8'h3C ^ 8'(f)};
          @(posedge clk); #1;
          ext_m = 8'h3C ^ 8'(f);
          chk(ext_q == ext_m, "R3 preload", {24'd0, ext_q}, {24'd0, ext_m});
        end
      end
    end
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    rst_n = 1'b0;
    #1 chk(ext_q == 8'h00, "R9 mid reset", {24'd0, ext_q}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    finish_run();
  end
endmodule